// File: doc/BRIEF.md
# Sleep and Wake-up State Controller

This block holds the power state of a small microcontroller and turns it into clock enables. After reset the system is operating: the CPU clock, the 32.768 kHz oscillator and the low-frequency peripheral domain all run. The CPU leaves this state by writing to the sleep address. One bit of the written data picks the sleep depth at that moment. With the bit set the oscillator keeps running and the block enters halt. With the bit clear everything stops and the block enters standby.

Four wake-up strobes bring the system back: a port key event, a timer 0 event, a fast tick (4/8/16/32 Hz) and a slow tick (2/1 Hz). A wake-enable register gates each strobe. A source is also qualified by the clocks still running. In standby only the key source can act, because the tick and timer sources stop with the oscillator. A wake-up ends in the operating state with the CPU clock enabled again, so the CPU goes on with its next instruction. No state outside this block is cleared. The controller runs from an always-on clock. Its register bus is only accepted while the CPU runs.

Top module: `pwr_state_ctl`

## Requirements
- R1: After reset, pwr_state is 0 (operating), cpu_clk_en, osc32_en and lf_clk_en are 1, and all four wake enables are set.
- R2: In operating, a bus write to address 0x09 with data bit 0 set gives pwr_state 1 (halt) from the next clock edge. In halt, cpu_clk_en is 0 while osc32_en and lf_clk_en stay 1.
- R3: In operating, a bus write to address 0x09 with data bit 0 clear gives pwr_state 2 (standby) from the next clock edge. In standby, all three enables are 0.
- R4: A write to any other address, or no write, leaves the operating state unchanged.
- R5: In halt, a strobe on an enabled source is registered at one edge. pwr_state returns to 0 and cpu_clk_en to 1 at the following edge.
- R6: In standby, only source 0 (key) can wake the block. Sources 1 (timer 0), 2 (fast tick) and 3 (slow tick) are ignored.
- R7: The wake-enable register sits at address 0x1C, with bit i enabling source i. A disabled source never causes a wake-up.
- R8: Wake strobes seen while operating leave nothing pending. A later sleep entry stays asleep.
- R9: Bus writes made while halted or in standby are ignored, to either address.
- R10: Reset returns the block to the operating state from halt and from standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register write address |
| bus_wdata | input | DATA_W | Register write data |
| wake_evt | input | NUM_SRC | Wake strobes: 0 key, 1 timer 0, 2 fast tick, 3 slow tick |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc32_en | output | 1 | 32.768 kHz oscillator enable |
| lf_clk_en | output | 1 | Low-frequency peripheral clock enable |
| pwr_state | output | 2 | 0 operating, 1 halt, 2 standby |

## Verification
The bench builds the block with its default values: 8-bit address and data, four sources, bit 0 as the depth select, and the low-frequency domain running in halt. With only four sources, it can sweep every wake-enable pattern against every source and both sleep depths, 128 cases in all. Each case gets an expected outcome worked out from the enable bit and the standby rule. Directed cases cover the exact cycle of entry and wake-up, leftover strobes from the operating state, writes made while asleep, and reset from each sleep state.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
   typedef enum logic [1:0] {
      PS_RUN  = 2'b00,
      PS_HALT = 2'b01,
      PS_STBY = 2'b10
   } pstate_e;

   localparam int unsigned SRC_KEY   = 0;
   localparam int unsigned SRC_TMR   = 1;
   localparam int unsigned SRC_FAST  = 2;
   localparam int unsigned SRC_SLOW  = 3;
endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
   import pwr_state_pkg::*;
#(
   parameter int unsigned        NUM_SRC   = 4,
   parameter logic [NUM_SRC-1:0] EN_RST    = '1,
   parameter logic [NUM_SRC-1:0] STBY_MASK = 'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [NUM_SRC-1:0] cfg_data,
   input  pstate_e            state,
   input  logic [NUM_SRC-1:0] wake_evt,
   output logic               wake_pend
);
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= EN_RST;
      else if (cfg_we) en_q <= cfg_data;
   end

   // Each source is qualified by its enable and by the clocks left running.
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (STBY_MASK[i]) begin : g_async
         assign hit[i] = wake_evt[i] && en_q[i] &&
                         (state == PS_HALT || state == PS_STBY);
      end else begin : g_lf
         assign hit[i] = wake_evt[i] && en_q[i] && (state == PS_HALT);
      end
   end

   // The pending flag lives for one cycle. It is never set while operating.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_pend <= 1'b0;
      else        wake_pend <= (state != PS_RUN) && !wake_pend && (|hit);
   end
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
   import pwr_state_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    sleep_req,
   input  logic    keep_osc,
   input  logic    wake_pend,
   output pstate_e state
);
   pstate_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         PS_RUN:  if (sleep_req) nxt = keep_osc ? PS_HALT : PS_STBY;
         PS_HALT,
         PS_STBY: if (wake_pend) nxt = PS_RUN;
         default: nxt = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PS_RUN;
      else        state <= nxt;
   end
endmodule

// File: rtl/pwr_clk_dec.sv
module pwr_clk_dec
   import pwr_state_pkg::*;
#(
   parameter bit LF_IN_HALT = 1'b1
) (
   input  pstate_e state,
   output logic    cpu_en,
   output logic    osc_en,
   output logic    lf_en
);
   assign cpu_en = (state == PS_RUN);
   assign osc_en = (state != PS_STBY);

   if (LF_IN_HALT) begin : g_lf_halt_on
      assign lf_en = (state != PS_STBY);
   end else begin : g_lf_halt_off
      assign lf_en = (state == PS_RUN);
   end
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
   import pwr_state_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned NUM_SRC      = 4,
   parameter int unsigned KEEP_OSC_BIT = 0,
   parameter logic [ADDR_W-1:0]  SLEEP_ADDR   = 8'h09,
   parameter logic [ADDR_W-1:0]  WAKE_EN_ADDR = 8'h1C,
   parameter logic [NUM_SRC-1:0] WAKE_EN_RST  = '1,
   parameter logic [NUM_SRC-1:0] STBY_MASK    = 'b1,
   parameter bit                 LF_IN_HALT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [NUM_SRC-1:0] wake_evt,
   output logic              cpu_clk_en,
   output logic              osc32_en,
   output logic              lf_clk_en,
   output logic [1:0]        pwr_state
);
   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_chk_src
      $error("NUM_SRC must be between 1 and DATA_W");
   end
   if (KEEP_OSC_BIT >= DATA_W) begin : g_chk_bit
      $error("KEEP_OSC_BIT outside the data word");
   end
   if (SLEEP_ADDR == WAKE_EN_ADDR) begin : g_chk_addr
      $error("sleep and wake-enable addresses collide");
   end

   pstate_e state;
   logic    bus_ok;
   logic    sleep_req;
   logic    cfg_we;
   logic    wake_pend;

   assign bus_ok    = bus_wr && (state == PS_RUN);
   assign sleep_req = bus_ok && (bus_addr == SLEEP_ADDR);
   assign cfg_we    = bus_ok && (bus_addr == WAKE_EN_ADDR);

   pwr_wake_qual #(
      .NUM_SRC   (NUM_SRC),
      .EN_RST    (WAKE_EN_RST),
      .STBY_MASK (STBY_MASK)
   ) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_data  (bus_wdata[NUM_SRC-1:0]),
      .state     (state),
      .wake_evt  (wake_evt),
      .wake_pend (wake_pend)
   );

   pwr_state_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (sleep_req),
      .keep_osc  (bus_wdata[KEEP_OSC_BIT]),
      .wake_pend (wake_pend),
      .state     (state)
   );

   pwr_clk_dec #(
      .LF_IN_HALT (LF_IN_HALT)
   ) u_dec (
      .state  (state),
      .cpu_en (cpu_clk_en),
      .osc_en (osc32_en),
      .lf_en  (lf_clk_en)
   );

   assign pwr_state = state;
endmodule

// File: rtl/pwr_state_ctl_chk.sv
module pwr_state_ctl_chk #(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned NUM_SRC      = 4,
   parameter int unsigned KEEP_OSC_BIT = 0,
   parameter logic [ADDR_W-1:0] SLEEP_ADDR = 8'h09
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [NUM_SRC-1:0] wake_evt,
   input logic              cpu_clk_en,
   input logic              osc32_en,
   input logic              lf_clk_en,
   input logic [1:0]        pwr_state
);
   logic sleep_wr;
   assign sleep_wr = bus_wr && (bus_addr == SLEEP_ADDR) && (pwr_state == 2'd0);

   assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_state != 2'd3);

   assert_cpu_needs_osc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en |-> (osc32_en && lf_clk_en));

   assert_enter_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_wr && bus_wdata[KEEP_OSC_BIT]) |=>
         (pwr_state == 2'd1 && !cpu_clk_en && osc32_en));

   assert_enter_stby_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_wr && !bus_wdata[KEEP_OSC_BIT]) |=>
         (pwr_state == 2'd2 && !cpu_clk_en && !osc32_en && !lf_clk_en));

   assert_stay_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd0 && !sleep_wr) |=> pwr_state == 2'd0);

   assert_stby_key_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd2 && !$past(wake_evt[0])) |=> pwr_state != 2'd0);
endmodule

bind pwr_state_ctl pwr_state_ctl_chk #(
   .ADDR_W       (ADDR_W),
   .DATA_W       (DATA_W),
   .NUM_SRC      (NUM_SRC),
   .KEEP_OSC_BIT (KEEP_OSC_BIT),
   .SLEEP_ADDR   (SLEEP_ADDR)
) u_chk (.*);

// File: tb/pwr_state_ctl_tb.sv
module pwr_state_ctl_tb;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_wr;
   logic [7:0] bus_addr;
   logic [7:0] bus_wdata;
   logic [3:0] wake_evt;
   logic       cpu_clk_en, osc32_en, lf_clk_en;
   logic [1:0] pwr_state;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_state_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .wake_evt(wake_evt), .cpu_clk_en(cpu_clk_en),
      .osc32_en(osc32_en), .lf_clk_en(lf_clk_en), .pwr_state(pwr_state)
   );

   task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // Packs {pwr_state, cpu, osc, lf} for comparison.
   function automatic logic [4:0] obs();
      return {pwr_state, cpu_clk_en, osc32_en, lf_clk_en};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; wake_evt = '0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic pulse(input logic [3:0] w);
      wake_evt = w;
      @(negedge clk);
      wake_evt = '0;
   endtask

   localparam logic [4:0] O_RUN  = 5'b00_111;
   localparam logic [4:0] O_HALT = 5'b01_011;
   localparam logic [4:0] O_STBY = 5'b10_000;

   initial begin
      rst_n = 1'b0;
      do_reset();
      check("R1 reset state", obs(), O_RUN);

      // R4: other addresses leave operating
      wr(8'h0A, 8'h01);
      wr(8'h1C, 8'h0F);
      @(negedge clk);
      check("R4 other address", obs(), O_RUN);

      // R2: halt entry and wake timing
      wr(8'h09, 8'h01);
      check("R2 halt entry", obs(), O_HALT);
      pulse(4'b0100);
      check("R5 wake registered, still halt", obs(), O_HALT);
      @(negedge clk);
      check("R5 wake back to run", obs(), O_RUN);

      // R3: standby entry
      wr(8'h09, 8'h00);
      check("R3 standby entry", obs(), O_STBY);
      pulse(4'b0001);
      @(negedge clk);
      check("R6 key wakes standby", obs(), O_RUN);

      // R8: strobes while operating leave nothing pending
      pulse(4'b1111);
      wr(8'h09, 8'h01);
      @(negedge clk); @(negedge clk);
      check("R8 no leftover wake", obs(), O_HALT);

      // R9: writes while asleep are ignored
      wr(8'h1C, 8'h00);
      wr(8'h09, 8'h00);
      @(negedge clk);
      check("R9 sleep write in halt ignored", obs(), O_HALT);
      pulse(4'b0001);
      @(negedge clk);
      check("R9 enable write in halt ignored", obs(), O_RUN);

      // R10: reset from halt and from standby
      wr(8'h09, 8'h01);
      do_reset();
      check("R10 reset from halt", obs(), O_RUN);
      wr(8'h09, 8'h00);
      do_reset();
      check("R10 reset from standby", obs(), O_RUN);

      // R5 R6 R7: sweep depth x enable pattern x source
      for (int depth = 0; depth < 2; depth++) begin
         for (int en = 0; en < 16; en++) begin
            for (int src = 0; src < 4; src++) begin
               logic    wakes;
               logic [3:0] e4;
               e4 = 4'(en);
               wakes = e4[src] && (depth == 1 || src == 0);
               wr(8'h1C, {4'b0, e4});
               wr(8'h09, {7'b0, 1'(depth)});
               pulse(4'b1 << src);
               @(negedge clk);
               @(negedge clk);
               if (depth == 1)
                  check(wakes ? "R5 R7 halt sweep wakes" : "R7 halt sweep disabled",
                        obs(), wakes ? O_RUN : O_HALT);
               else
                  check(wakes ? "R6 R7 standby sweep wakes" : "R6 R7 standby sweep ignored",
                        obs(), wakes ? O_RUN : O_STBY);
               if (!wakes) do_reset();
            end
         end
      end

      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule